// File: doc/BRIEF.md
# Phase-Toggle Stream Pump

The pump moves short groups of bytes from a producer to a consumer. Each group is a word of up to four bytes and a count of how many of them are valid. Both neighbours speak the same request convention. The pump asks for work by inverting a phase output. The neighbour first lowers its ready input to show that it has seen the request, and it raises ready again when the request is complete.

The pump keeps exactly one group in flight. It fetches a group from the producer and registers the word and its length. It offers that group to the consumer and waits for the consumer to finish. Only then does it fetch the next group. A slow consumer therefore holds back the producer, and no group is lost or overwritten.

Groups that report zero valid bytes are dropped and the pump fetches again. A count above the word's capacity is treated as a full word. Byte lanes beyond the valid count are cleared before the group reaches the consumer.

Top module: `phase_stream_pump`

## Requirements
- R1: A fetch is requested by inverting `src_phase`. Exactly one inversion is made per group fetched, and the phase never inverts on two consecutive clock edges.
- R2: A request on either side completes only when its ready input has been seen low at a clock edge after the inversion, and then seen high. A ready that stays high from an earlier transfer does not complete a request.
- R3: No new fetch is requested while the consumer request is outstanding, and the two sides are never busy at the same time.
- R4: Each group with a non-zero length is offered by inverting `snk_phase` once. `snk_data` and `snk_len` stay stable from that inversion until the consumer completes.
- R5: A group returned with length 0 is not offered to the consumer, and the next fetch is requested instead. A length of 5 to 7 is offered as length 4.
- R6: Valid bytes occupy the low-order lanes, with byte 0 in bits 7:0. Every byte lane at or above `snk_len` reads as 0x00.
- R7: Groups reach the consumer in the order they were fetched, with their data unchanged in the valid lanes.
- R8: A synchronous active-low reset drives both phase outputs, `snk_data` and `snk_len` to 0. After reset is released the pump starts by requesting a fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_phase | output | 1 | Fetch request; inverted once per request |
| src_ready | input | 1 | Producer ready; low means the request has been seen, high means it is done |
| src_data | input | 32 | Word returned by the producer |
| src_len | input | 3 | Number of valid bytes in `src_data` |
| snk_phase | output | 1 | Delivery request; inverted once per group |
| snk_ready | input | 1 | Consumer ready; low means the request has been seen, high means it is done |
| snk_data | output | 32 | Registered group word, with unused lanes cleared |
| snk_len | output | 3 | Registered valid-byte count, from 1 to 4 |

## Verification
Two events fall close together in time: the consumer finishing a group, and the pump issuing its next fetch. A design that overlaps them would start a fetch while a delivery is still pending. The consumer model provokes this by holding delivery requests for random and sometimes long spans. It samples `src_phase` on every cycle of that span and flags any inversion.

The other coincidence is a producer ready that is still high at the moment a new fetch is issued. The producer model leaves ready high before its first response. It also answers nothing after its last group, so a pump that takes a stale ready as completion delivers an extra or corrupted group. The bench judges this by comparing every delivered word and length against its own list and by counting the fetch requests.

// File: rtl/pump_pkg.sv
// Shared state encodings for the phase-toggle stream pump.
package pump_pkg;

    // Per-side request progress: idle, waiting for ready to fall, waiting for ready to rise.
    typedef enum logic [1:0] {
        HS_IDLE      = 2'd0,
        HS_WAIT_LOW  = 2'd1,
        HS_WAIT_HIGH = 2'd2
    } hs_state_t;

    // Top-level pump sequence.
    typedef enum logic [1:0] {
        PF_FETCH   = 2'd0,
        PF_RD_WAIT = 2'd1,
        PF_PUT     = 2'd2,
        PF_WR_WAIT = 2'd3
    } pump_state_t;

endpackage

// File: rtl/toggle_requester.sv
// toggle_requester
// Issues one request toward a neighbour by inverting `phase`, then tracks
// the neighbour's ready line until the request is finished.
// Assumes the neighbour lowers ready to acknowledge the inversion and
// raises it on completion. A ready that is already high when the request
// starts is ignored until it has been seen low at least once.
// `start` is honoured only while idle. `done` is a one-cycle combinational
// pulse during the cycle in which the completing ready is sampled.
module toggle_requester
    import pump_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ready,
    output logic phase,
    output logic busy,
    output logic done
);

    hs_state_t state;

    // Request sequencing: invert phase on start, then wait for ready low followed by ready high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HS_IDLE;
            phase <= 1'b0;
        end else begin
            unique case (state)
                HS_IDLE: begin
                    if (start) begin
                        phase <= ~phase;
                        state <= HS_WAIT_LOW;
                    end
                end
                HS_WAIT_LOW: begin
                    if (!ready) begin
                        state <= HS_WAIT_HIGH;
                    end
                end
                HS_WAIT_HIGH: begin
                    if (ready) begin
                        state <= HS_IDLE;
                    end
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

    // Status decode for the pump sequencer.
    always_comb begin
        busy = (state != HS_IDLE);
        done = (state == HS_WAIT_HIGH) && ready;
    end

endmodule

// File: rtl/group_holder.sv
// group_holder
// Holds the single in-flight byte group between fetch and delivery.
// On `load` it stores the length, clamped to the word capacity, and the
// word with every lane at or above that length cleared. It also reports
// combinationally whether the incoming group is empty, so that the
// sequencer can drop it.
// Assumes LEN_W bits can represent DATA_BYTES.
module group_holder #(
    parameter int DATA_BYTES = 4,
    parameter int LEN_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [DATA_BYTES*8-1:0] in_data,
    input  logic [LEN_W-1:0]        in_len,
    output logic                    in_empty,
    output logic [DATA_BYTES*8-1:0] out_data,
    output logic [LEN_W-1:0]        out_len
);

    localparam int DATA_W = DATA_BYTES * 8;
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(DATA_BYTES);

    logic [LEN_W-1:0]  eff_len;
    logic [DATA_W-1:0] masked;

    // Length clamp and empty-group detection.
    always_comb begin
        eff_len  = (in_len > MAX_LEN) ? MAX_LEN : in_len;
        in_empty = (in_len == '0);
    end

    // Per-lane masking: a lane is kept only if its index is below the length.
    for (genvar gi = 0; gi < DATA_BYTES; gi++) begin : g_lane
        assign masked[gi*8 +: 8] = (eff_len > LEN_W'(gi)) ? in_data[gi*8 +: 8] : 8'h00;
    end

    // Group register: capture on load, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_len  <= '0;
        end else if (load) begin
            out_data <= masked;
            out_len  <= eff_len;
        end
    end

endmodule

// File: rtl/phase_stream_pump.sv
// phase_stream_pump
// Moves byte groups from a toggle/ready producer to a toggle/ready consumer
// with one group in flight. The sequence is: fetch, capture, deliver,
// wait for the consumer, then fetch again. Zero-length groups are dropped
// without a delivery.
// Assumes both neighbours lower ready to acknowledge a phase inversion
// and raise it to signal completion.
module phase_stream_pump
    import pump_pkg::*;
#(
    parameter int DATA_BYTES = 4,
    parameter int LEN_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic                    src_phase,
    input  logic                    src_ready,
    input  logic [DATA_BYTES*8-1:0] src_data,
    input  logic [LEN_W-1:0]        src_len,
    output logic                    snk_phase,
    input  logic                    snk_ready,
    output logic [DATA_BYTES*8-1:0] snk_data,
    output logic [LEN_W-1:0]        snk_len
);

    pump_state_t state, state_nx;
    logic rd_start, rd_busy, rd_done;
    logic wr_start, wr_busy, wr_done;
    logic grp_load, grp_empty;

    // Producer-side request tracker.
    toggle_requester u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rd_start),
        .ready (src_ready),
        .phase (src_phase),
        .busy  (rd_busy),
        .done  (rd_done)
    );

    // Consumer-side request tracker.
    toggle_requester u_wr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_start),
        .ready (snk_ready),
        .phase (snk_phase),
        .busy  (wr_busy),
        .done  (wr_done)
    );

    // The one-deep group register between the two sides.
    group_holder #(
        .DATA_BYTES (DATA_BYTES),
        .LEN_W      (LEN_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (grp_load),
        .in_data  (src_data),
        .in_len   (src_len),
        .in_empty (grp_empty),
        .out_data (snk_data),
        .out_len  (snk_len)
    );

    // Sequencer next-state and strobes.
    always_comb begin
        state_nx = state;
        rd_start = 1'b0;
        wr_start = 1'b0;
        grp_load = 1'b0;
        unique case (state)
            PF_FETCH: begin
                rd_start = 1'b1;
                state_nx = PF_RD_WAIT;
            end
            PF_RD_WAIT: begin
                if (rd_done) begin
                    grp_load = 1'b1;
                    state_nx = grp_empty ? PF_FETCH : PF_PUT;
                end
            end
            PF_PUT: begin
                wr_start = 1'b1;
                state_nx = PF_WR_WAIT;
            end
            PF_WR_WAIT: begin
                if (wr_done) begin
                    state_nx = PF_FETCH;
                end
            end
            default: state_nx = PF_FETCH;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PF_FETCH;
        end else begin
            state <= state_nx;
        end
    end

endmodule

// File: rtl/pump_checker.sv
// pump_checker
// Temporal properties of phase_stream_pump, attached to it with a bind.
// Observes the phase outputs, the delivered group, and the busy flags of
// the two request trackers.
module pump_checker #(
    parameter int DATA_BYTES = 4,
    parameter int LEN_W      = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    src_phase,
    input logic                    snk_phase,
    input logic [DATA_BYTES*8-1:0] snk_data,
    input logic [LEN_W-1:0]        snk_len,
    input logic                    rd_busy,
    input logic                    wr_busy
);

    logic hi_zero;

    // Lanes at or above the delivered length must be clear.
    always_comb begin
        hi_zero = 1'b1;
        for (int b = 0; b < DATA_BYTES; b++) begin
            if ((b >= int'(snk_len)) && (snk_data[b*8 +: 8] != 8'h00)) hi_zero = 1'b0;
        end
    end

    AST_SRC_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (src_phase != $past(src_phase)) |=> (src_phase == $past(src_phase))); // R1

    AST_NO_FETCH_DURING_PUT: assert property (@(posedge clk) disable iff (!rst_n)
        (src_phase != $past(src_phase)) |-> !$past(wr_busy)); // R3

    AST_ONE_SIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_busy && wr_busy)); // R3

    AST_GROUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> ($stable(snk_data) && $stable(snk_len))); // R4

    AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_phase != $past(snk_phase)) |-> ((snk_len != '0) && (snk_len <= LEN_W'(DATA_BYTES)))); // R5

    AST_UPPER_LANES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_phase != $past(snk_phase)) |-> hi_zero); // R6

endmodule

bind phase_stream_pump pump_checker #(
    .DATA_BYTES (DATA_BYTES),
    .LEN_W      (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_phase (src_phase),
    .snk_phase (snk_phase),
    .snk_data  (snk_data),
    .snk_len   (snk_len),
    .rd_busy   (rd_busy),
    .wr_busy   (wr_busy)
);

// File: tb/phase_stream_pump_tb.sv
// Self-checking bench: reactive producer and consumer models with random
// latencies, a fixed seed, and directed corner groups at the start.
module phase_stream_pump_tb;

    localparam int NG = 150;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_phase, snk_phase;
    logic        src_ready = 1'b1;
    logic [31:0] src_data = 32'hDEAD_BEEF;
    logic [2:0]  src_len = 3'd5;
    logic        snk_ready = 1'b1;
    logic [31:0] snk_data;
    logic [2:0]  snk_len;

    int vectors = 0;
    int misses  = 0;
    int reads   = 0;
    int served  = 0;
    int got     = 0;
    int n_exp   = 0;
    logic [31:0] gen_word [NG];
    logic [2:0]  gen_len  [NG];
    logic [31:0] exp_word [NG];
    logic [2:0]  exp_len  [NG];

    always #10 clk = ~clk;

    phase_stream_pump u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_phase (src_phase),
        .src_ready (src_ready),
        .src_data  (src_data),
        .src_len   (src_len),
        .snk_phase (snk_phase),
        .snk_ready (snk_ready),
        .snk_data  (snk_data),
        .snk_len   (snk_len)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R5: clamp of the delivered length.
    function automatic logic [2:0] eff_len(input logic [2:0] l);
        return (l > 3'd4) ? 3'd4 : l;
    endfunction

    // R6: lanes at or above the length are cleared.
    function automatic logic [31:0] mask_word(input logic [31:0] w, input logic [2:0] l);
        logic [31:0] r;
        r = 32'h0;
        for (int b = 0; b < 4; b++) if (b < int'(l)) r[b*8 +: 8] = w[b*8 +: 8];
        return r;
    endfunction

    // Producer model: acknowledges each inversion by lowering ready, then returns a group.
    initial begin : producer
        logic seen;
        seen = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && (src_phase != seen)) begin
                seen = src_phase;
                reads++;
                if (served < NG) begin
                    repeat ($urandom_range(0, 3)) @(negedge clk);
                    src_ready = 1'b0;
                    src_data  = $urandom;
                    src_len   = 3'($urandom_range(0, 7));
                    repeat ($urandom_range(1, 3)) @(negedge clk);
                    src_data  = gen_word[served];
                    src_len   = gen_len[served];
                    src_ready = 1'b1;
                    served++;
                end
                // After the last group ready stays high: a stale ready (R2).
            end
        end
    end

    // Consumer model: checks each offered group, holds it for a random span, and watches src_phase.
    initial begin : consumer
        logic seen, sp;
        bit flow_ok;
        seen = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && (snk_phase != seen)) begin
                seen = snk_phase;
                if (got < n_exp) begin
                    chk(snk_data == exp_word[got], "R7/R6 data", snk_data, exp_word[got]);
                    chk(snk_len == exp_len[got], "R5/R4 len", {29'h0, snk_len}, {29'h0, exp_len[got]});
                end else begin
                    chk(1'b0, "R2 extra delivery", {31'h0, snk_phase}, 32'h0);
                end
                sp = src_phase;
                flow_ok = 1'b1;
                repeat (($urandom_range(0, 9) == 0) ? 25 : $urandom_range(0, 4)) begin
                    @(negedge clk);
                    if (src_phase != sp) flow_ok = 1'b0;
                end
                snk_ready = 1'b0;
                repeat ($urandom_range(1, 2)) begin
                    @(negedge clk);
                    if (src_phase != sp) flow_ok = 1'b0;
                end
                chk(flow_ok, "R3 fetch during delivery", {31'h0, src_phase}, {31'h0, sp});
                snk_ready = 1'b1;
                got++;
            end
        end
    end

    initial begin : main
        int r;
        bit finished;
        void'($urandom(32'h5EED_1234));
        // Directed corner groups first, then random groups.
        gen_word[0] = 32'h4433_2211; gen_len[0] = 3'd4;
        gen_word[1] = 32'hFFFF_FFFF; gen_len[1] = 3'd0;
        gen_word[2] = 32'hA5A5_5A5A; gen_len[2] = 3'd7;
        gen_word[3] = 32'hFFFF_FF81; gen_len[3] = 3'd1;
        gen_word[4] = 32'h1234_5678; gen_len[4] = 3'd0;
        gen_word[5] = 32'hCAFE_0102; gen_len[5] = 3'd2;
        gen_word[6] = 32'h0BAD_F00D; gen_len[6] = 3'd3;
        gen_word[7] = 32'h7777_7777; gen_len[7] = 3'd5;
        for (int i = 8; i < NG; i++) begin
            r = $urandom_range(0, 9);
            gen_word[i] = $urandom;
            gen_len[i]  = (r == 0) ? 3'd0 : (r == 1) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(1, 4));
        end
        for (int i = 0; i < NG; i++) begin
            if (gen_len[i] != 3'd0) begin
                exp_len[n_exp]  = eff_len(gen_len[i]);
                exp_word[n_exp] = mask_word(gen_word[i], eff_len(gen_len[i]));
                n_exp++;
            end
        end

        repeat (4) @(negedge clk);
        chk(src_phase == 1'b0, "R8 src_phase reset", {31'h0, src_phase}, 32'h0);
        chk(snk_phase == 1'b0, "R8 snk_phase reset", {31'h0, snk_phase}, 32'h0);
        chk(snk_data == 32'h0, "R8 snk_data reset", snk_data, 32'h0);
        chk(snk_len == 3'd0, "R8 snk_len reset", {29'h0, snk_len}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(reads == 1, "R8 first fetch after reset", reads, 32'd1);

        finished = 1'b0;
        for (int c = 0; c < 150000; c++) begin
            @(negedge clk);
            if ((got == n_exp) && (served == NG)) begin
                finished = 1'b1;
                break;
            end
        end
        chk(finished, "watchdog", got, n_exp);
        repeat (60) @(negedge clk);
        chk(got == n_exp, "R5/R2 delivery count", got, n_exp);
        chk(reads == NG + 1, "R1 fetch count", reads, NG + 1);
        chk(snk_ready == 1'b1, "R4 consumer idle at end", {31'h0, snk_ready}, 32'h1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule